// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two predictors run side by side. The first is a two-level local predictor: a per-branch history table, selected by PC bits, supplies a history pattern, and that pattern picks a 2-bit counter. The second is a global predictor, in which a shift register of recent outcomes from all branches picks a 2-bit counter. A third table of 2-bit counters, also selected by PC bits, learns for each branch which of the two predictors to trust. It drives the final choice between them.

The front end presents a PC on the predict port. One clock later it receives the final direction and the two component directions. When the branch resolves, the back end returns the PC, the real outcome and the two component directions it was given. The block then trains both component counters, shifts both histories and, where the components disagreed, moves the selector. Histories are not repaired after a misprediction, and target addresses are not predicted.

Top module: `tournament_bp`

## Requirements
- R1: After a synchronous active-high reset, every local and global counter holds 1 (weakly not-taken), every selector counter holds 1 (leaning local), and every history is zero, so all three prediction outputs read 0 for any PC.
- R2: Every counter is 2 bits wide and saturates at 0 and 3. A taken outcome adds one and a not-taken outcome subtracts one. A counter value of 2 or 3 means taken.
- R3: The local prediction reads the history entry selected by pc[2 +: LHT_IDX_W], and that LHIST_W-bit history selects the local counter.
- R4: The global prediction uses the GHIST_W-bit global history register to select the global counter.
- R5: The selector counter selected by pc[2 +: SEL_IDX_W] picks the final prediction. A value of 2 or 3 outputs the global prediction; 0 or 1 outputs the local prediction.
- R6: On update, the selector entry steps toward the global side when only the global prediction matched the outcome, and toward the local side when only the local one did. It stays unchanged when both matched or both missed.
- R7: On every update, whichever component was selected, the local counter at the branch's current local history and the global counter at the current global history both train on the outcome. Then the branch's history entry and the global history each shift left, with the outcome entering bit 0.
- R8: Predictions are registered. A PC presented before a clock edge yields outputs after that edge, computed from table contents as they were before any update taken at the same edge.
- R9: While upd_valid is low, the update inputs have no effect on any table or history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_pc | input | PC_W | PC of the branch to predict |
| pred_taken | output | 1 | Final predicted direction (1 = taken) |
| pred_local | output | 1 | Local component prediction |
| pred_global | output | 1 | Global component prediction |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| upd_local | input | 1 | Local prediction given for this branch |
| upd_global | input | 1 | Global prediction given for this branch |

## Verification
The bench targets counter saturation at both ends. A design that wraps instead of saturating flips a strongly biased branch to the wrong direction after one extra outcome. It also exercises selector training with agreeing and disagreeing component inputs. A selector that trains on agreement, or moves the wrong way, picks the weaker predictor and diverges from the model's final prediction. Further scenarios present a prediction in the same cycle as an update to the same branch, which exposes any forwarding of the new state. Idle cycles with toggling update inputs expose a design that writes without upd_valid. Long repeating patterns show whether the history shift order and the counter index are correct, because a wrong order learns a different pattern from the model.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'd1;
  localparam ctr2_t CTR_MAX     = 2'd3;
  localparam ctr2_t CTR_MIN     = 2'd0;

  // Saturating step toward the outcome.
  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == CTR_MAX) ? c : c + 2'd1;
    else    r = (c == CTR_MIN) ? c : c - 2'd1;
    return r;
  endfunction

  // Upper half of the range means taken.
  function automatic logic ctr_says_taken(input ctr2_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/bp_local.sv
module bp_local
  import bp_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int L1_N = 1 << IDX_W;
  localparam int L2_N = 1 << HIST_W;

  logic [HIST_W-1:0] hist_tab [L1_N];
  ctr2_t             ctr_tab  [L2_N];

  logic [HIST_W-1:0] rd_hist;
  logic [HIST_W-1:0] wr_hist;

  assign rd_hist = hist_tab[rd_idx];
  assign wr_hist = hist_tab[wr_idx];

  // Registered read of the second level.
  always_ff @(posedge clk) begin
    if (rst) rd_taken <= 1'b0;
    else     rd_taken <= ctr_says_taken(ctr_tab[rd_hist]);
  end

  // First level: per-branch outcome history.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < L1_N; k++) hist_tab[k] <= '0;
    end else if (wr_en) begin
      hist_tab[wr_idx] <= {wr_hist[HIST_W-2:0], wr_taken};
    end
  end

  // Second level: pattern counters.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < L2_N; k++) ctr_tab[k] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      ctr_tab[wr_hist] <= ctr_step(ctr_tab[wr_hist], wr_taken);
    end
  end

  AST_LHIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> hist_tab[$past(wr_idx)][0] == $past(wr_taken)); // R7

  AST_LCTR_UP_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken) |=> ctr_tab[$past(wr_hist)] >= $past(ctr_tab[wr_hist])); // R2

  AST_LCTR_DN_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken) |=> ctr_tab[$past(wr_hist)] <= $past(ctr_tab[wr_hist])); // R2

endmodule

// File: rtl/bp_global.sv
module bp_global
  import bp_pkg::*;
#(
  parameter int HIST_W = 6
) (
  input  logic clk,
  input  logic rst,
  output logic rd_taken,
  input  logic wr_en,
  input  logic wr_taken
);
  localparam int TAB_N = 1 << HIST_W;

  logic [HIST_W-1:0] ghr;
  ctr2_t             ctr_tab [TAB_N];

  always_ff @(posedge clk) begin
    if (rst) rd_taken <= 1'b0;
    else     rd_taken <= ctr_says_taken(ctr_tab[ghr]);
  end

  always_ff @(posedge clk) begin
    if (rst)        ghr <= '0;
    else if (wr_en) ghr <= {ghr[HIST_W-2:0], wr_taken};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAB_N; k++) ctr_tab[k] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      ctr_tab[ghr] <= ctr_step(ctr_tab[ghr], wr_taken);
    end
  end

  AST_GHR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ghr)); // R9

  AST_GHR_NEWEST: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ghr[0] == $past(wr_taken)); // R7

  AST_GCTR_UP_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken) |=> ctr_tab[$past(ghr)] >= $past(ctr_tab[ghr])); // R2

endmodule

// File: rtl/bp_chooser.sv
module bp_chooser
  import bp_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_use_global,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  input  logic             wr_local,
  input  logic             wr_global
);
  localparam int TAB_N = 1 << IDX_W;

  ctr2_t sel_tab [TAB_N];

  logic disagree;
  logic global_right;

  assign disagree     = wr_local ^ wr_global;
  assign global_right = (wr_global == wr_taken);

  always_ff @(posedge clk) begin
    if (rst) rd_use_global <= 1'b0;
    else     rd_use_global <= ctr_says_taken(sel_tab[rd_idx]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAB_N; k++) sel_tab[k] <= CTR_WEAK_NT;
    end else if (wr_en && disagree) begin
      sel_tab[wr_idx] <= ctr_step(sel_tab[wr_idx], global_right);
    end
  end

  AST_SEL_AGREE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_local == wr_global)) |=> sel_tab[$past(wr_idx)] == $past(sel_tab[wr_idx])); // R6

  AST_SEL_TOWARD_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_local != wr_global) && (wr_global == wr_taken))
      |=> sel_tab[$past(wr_idx)] >= $past(sel_tab[wr_idx])); // R6

  AST_SEL_TOWARD_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_local != wr_global) && (wr_local == wr_taken))
      |=> sel_tab[$past(wr_idx)] <= $past(sel_tab[wr_idx])); // R6

endmodule

// File: rtl/tournament_bp.sv
module tournament_bp #(
  parameter int PC_W      = 32,
  parameter int LHT_IDX_W = 4,
  parameter int LHIST_W   = 4,
  parameter int GHIST_W   = 6,
  parameter int SEL_IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local,
  input  logic            upd_global
);
  localparam int PC_LSB = 2;

  logic use_global;
  logic unused_pc_bits;

  assign unused_pc_bits = ^{pred_pc, upd_pc};

  bp_local #(
    .IDX_W  (LHT_IDX_W),
    .HIST_W (LHIST_W)
  ) u_local (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (pred_pc[PC_LSB +: LHT_IDX_W]),
    .rd_taken (pred_local),
    .wr_en    (upd_valid),
    .wr_idx   (upd_pc[PC_LSB +: LHT_IDX_W]),
    .wr_taken (upd_taken)
  );

  bp_global #(
    .HIST_W (GHIST_W)
  ) u_global (
    .clk      (clk),
    .rst      (rst),
    .rd_taken (pred_global),
    .wr_en    (upd_valid),
    .wr_taken (upd_taken)
  );

  bp_chooser #(
    .IDX_W (SEL_IDX_W)
  ) u_chooser (
    .clk           (clk),
    .rst           (rst),
    .rd_idx        (pred_pc[PC_LSB +: SEL_IDX_W]),
    .rd_use_global (use_global),
    .wr_en         (upd_valid),
    .wr_idx        (upd_pc[PC_LSB +: SEL_IDX_W]),
    .wr_taken      (upd_taken),
    .wr_local      (upd_local),
    .wr_global     (upd_global)
  );

  // Final choice between two registered component results.
  assign pred_taken = use_global ? pred_global : pred_local;

  AST_AGREE_PASS: assert property (@(posedge clk) disable iff (rst)
    (pred_local == pred_global) |-> (pred_taken == pred_local)); // R5

  AST_OUT_FROM_COMPONENT: assert property (@(posedge clk) disable iff (rst)
    (pred_taken == pred_local) || (pred_taken == pred_global)); // R5

endmodule

// File: tb/sim_tournament_bp.sv
module sim_tournament_bp;
  localparam int PC_W = 32;
  localparam int LI   = 4;
  localparam int LH   = 4;
  localparam int GH   = 6;
  localparam int SI   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] pred_pc = '0;
  logic            pred_taken, pred_local, pred_global;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0, upd_local = 1'b0, upd_global = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  tournament_bp #(
    .PC_W(PC_W), .LHT_IDX_W(LI), .LHIST_W(LH), .GHIST_W(GH), .SEL_IDX_W(SI)
  ) u0 (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_local(pred_local), .pred_global(pred_global), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_local(upd_local),
    .upd_global(upd_global)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Reference state written from the requirements.
  logic [LH-1:0] m_lht  [1<<LI];
  logic [1:0]    m_lpht [1<<LH];
  logic [1:0]    m_gpht [1<<GH];
  logic [1:0]    m_sel  [1<<SI];
  logic [GH-1:0] m_ghr;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  function automatic logic m_local(input logic [PC_W-1:0] pc);
    return m_lpht[m_lht[pc[2 +: LI]]] >= 2'd2;
  endfunction

  function automatic logic m_global();
    return m_gpht[m_ghr] >= 2'd2;
  endfunction

  function automatic logic m_final(input logic [PC_W-1:0] pc);
    return (m_sel[pc[2 +: SI]] >= 2'd2) ? m_global() : m_local(pc);
  endfunction

  task automatic m_clear();
    for (int k = 0; k < (1<<LI); k++) m_lht[k] = '0;
    for (int k = 0; k < (1<<LH); k++) m_lpht[k] = 2'd1;
    for (int k = 0; k < (1<<GH); k++) m_gpht[k] = 2'd1;
    for (int k = 0; k < (1<<SI); k++) m_sel[k] = 2'd1;
    m_ghr = '0;
  endtask

  task automatic m_update(input logic [PC_W-1:0] pc, input logic t,
                          input logic l, input logic g);
    logic [LI-1:0] li;
    li = pc[2 +: LI];
    if (l != g) m_sel[pc[2 +: SI]] = sat(m_sel[pc[2 +: SI]], g == t);
    m_lpht[m_lht[li]] = sat(m_lpht[m_lht[li]], t);
    m_lht[li] = {m_lht[li][LH-2:0], t};
    m_gpht[m_ghr] = sat(m_gpht[m_ghr], t);
    m_ghr = {m_ghr[GH-2:0], t};
  endtask

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic apply_reset();
    rst = 1'b1; upd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_clear();
  endtask

  task automatic predict(input string tag, input logic [PC_W-1:0] pc);
    logic el, eg, ef;
    el = m_local(pc); eg = m_global(); ef = m_final(pc);
    pred_pc = pc;
    @(negedge clk);
    check(tag, "local", pred_local, el);
    check(tag, "global", pred_global, eg);
    check(tag, "final", pred_taken, ef);
  endtask

  task automatic update(input logic [PC_W-1:0] pc, input logic t,
                        input logic l, input logic g);
    upd_pc = pc; upd_taken = t; upd_local = l; upd_global = g;
    upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    m_update(pc, t, l, g);
  endtask

  // Predict, then resolve with the component values the model gave.
  task automatic step(input string tag, input logic [PC_W-1:0] pc, input logic t);
    logic l, g;
    predict(tag, pc);
    l = pred_local; g = pred_global;
    update(pc, t, l, g);
  endtask

  task automatic t_reset();
    apply_reset();
    for (int k = 0; k < 6; k++) begin
      pred_pc = 32'h100 + 32'(k * 4);
      @(negedge clk);
      check("R1", "local after reset", pred_local, 1'b0);
      check("R1", "global after reset", pred_global, 1'b0);
      check("R1", "final after reset", pred_taken, 1'b0);
    end
  endtask

  task automatic t_saturate();
    apply_reset();
    for (int k = 0; k < 10; k++) step("R2", 32'h40, 1'b1);
    for (int k = 0; k < 3; k++) step("R2", 32'h40, 1'b0);
    for (int k = 0; k < 10; k++) step("R2", 32'h40, 1'b0);
    step("R2", 32'h40, 1'b1);
    predict("R2", 32'h40);
  endtask

  task automatic t_patterns();
    apply_reset();
    for (int k = 0; k < 60; k++) begin
      step("R3", 32'h10, (k % 3) != 0);
      step("R4", 32'h24, k[0]);
    end
    for (int k = 0; k < 40; k++) step("R7", 32'h3C, (k % 4) == 1);
  endtask

  task automatic t_selector();
    apply_reset();
    // Only global correct, twice: selector climbs to the global side.
    update(32'h08, 1'b1, 1'b0, 1'b1);
    update(32'h08, 1'b1, 1'b0, 1'b1);
    predict("R5", 32'h08);
    // Agreement (both right, both wrong) leaves it in place.
    for (int k = 0; k < 4; k++) update(32'h08, k[0], k[0], k[0]);
    for (int k = 0; k < 4; k++) update(32'h08, k[0], !k[0], !k[0]);
    predict("R6", 32'h08);
    for (int k = 0; k < 30; k++) begin
      update(32'h08, k[1], !k[1] ^ k[0], k[1] ^ k[0]);
      predict("R6", 32'h08);
      predict("R5", 32'h0C);
    end
    // Only local correct, repeatedly: selector floors on the local side.
    for (int k = 0; k < 5; k++) update(32'h08, 1'b0, 1'b0, 1'b1);
    predict("R6", 32'h08);
  endtask

  task automatic t_idle();
    apply_reset();
    for (int k = 0; k < 8; k++) step("R9", 32'h14, 1'b1);
    for (int k = 0; k < 12; k++) begin
      upd_valid = 1'b0; upd_pc = 32'h14 + 32'(k * 4);
      upd_taken = k[0]; upd_local = k[1]; upd_global = !k[0];
      @(negedge clk);
    end
    predict("R9", 32'h14);
    predict("R9", 32'h18);
  endtask

  task automatic t_same_cycle();
    logic el, eg, ef;
    apply_reset();
    for (int k = 0; k < 3; k++) update(32'h20, 1'b1, 1'b1, 1'b0);
    // Predict and update the same branch at one edge: old state is seen.
    el = m_local(32'h20); eg = m_global(); ef = m_final(32'h20);
    pred_pc = 32'h20;
    upd_pc = 32'h20; upd_taken = 1'b1; upd_local = 1'b0; upd_global = 1'b1;
    upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    check("R8", "local same edge", pred_local, el);
    check("R8", "global same edge", pred_global, eg);
    check("R8", "final same edge", pred_taken, ef);
    m_update(32'h20, 1'b1, 1'b0, 1'b1);
    predict("R8", 32'h20);
  endtask

  task automatic t_random();
    logic [PC_W-1:0] pc;
    logic t, l, g;
    apply_reset();
    for (int k = 0; k < 3000; k++) begin
      pc = 32'($urandom_range(0, 15)) << 2;
      t  = (pc[3:2] == 2'd0) ? k[0] : ($urandom_range(0, 3) != 0);
      predict("R5", pc);
      l = pred_local; g = pred_global;
      if ($urandom_range(0, 3) == 0) begin l = $urandom_range(0, 1); g = $urandom_range(0, 1); end
      update(pc, t, l, g);
    end
  endtask

  initial begin
    t_reset();
    t_saturate();
    t_patterns();
    t_selector();
    t_idle();
    t_same_cycle();
    t_random();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule